// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block sends stereo samples out over a single serial data line. A left and right sample pair arrives on a parallel bus with a valid/ready handshake. The block shifts the pair out under a bit clock and a word clock. The word clock is low while the left word is on the line and high while the right word is on the line. Each channel half always spans 32 bit clocks. The block offers three placements of the sample inside a half:

- **Standard format:** the MSB is one bit clock late.
- **Left-aligned:** the MSB starts on the word-clock change.
- **Right-aligned:** the LSB ends exactly at the next word-clock change.

Slots not covered by the sample carry zero.

The block can drive the link clocks itself. In that case it divides its system clock by a programmable amount. It can instead follow a bit clock and word clock driven by the far end. In that case it synchronizes them into the system clock domain and acts on their detected edges.

A new pair is taken once per frame, at the start of the left half. If no pair is offered at that point, the frame is sent as zeros and a sticky underrun flag is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: With `is_master` high, `clk_oe` is 1 and `bclk_o` stays high and low for `half_div`+1 system clocks each. With `is_master` low, `clk_oe`, `bclk_o` and `wclk_o` are all 0.
- R2: Each channel half holds exactly 32 bit clocks. The word clock is 0 for the left half and 1 for the right half, and it changes only right after a falling bit-clock edge.
- R3: `sdata` changes only after a falling bit-clock edge, so it is stable at every rising edge, where the far end samples it.
- R4: With `fmt_sel` = 2'b01 (left-aligned), the sample MSB sits in slot 0 of its half.
- R5: With `fmt_sel` = 2'b00 or 2'b11 (standard), the MSB sits in slot 1. For a 32-bit size, the LSB spills into slot 0 of the following half; for smaller sizes, slot 0 is 0.
- R6: With `fmt_sel` = 2'b10 (right-aligned), the LSB sits in slot 31 and the MSB sits in slot 32 minus the sample size.
- R7: `size_sel` selects the sample size: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Input samples are LSB-aligned, so bits above the size are ignored. All slots outside the sample are sent as 0.
- R8: `smp_ready` is a one-cycle pulse issued once per frame, at the start of the left half. The pair on the sample inputs is taken when `smp_valid` is high in that cycle.
- R9: If `smp_valid` is low when `smp_ready` pulses, both halves of that frame carry only zeros. `underrun` then becomes 1 and stays 1 until reset.
- R10: In slave mode, the block follows `bclk_in` and `wclk_in`. A new half begins at the first falling bit-clock edge at which a changed word-clock level is seen. The data placement follows R4 to R7.
- R11: During reset, the outputs take these values:
  - `sdata` = 0, `underrun` = 0 and `smp_ready` = 0.
  - In master mode, `bclk_o` = 0 and `wclk_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_left | input | 32 | Left sample, LSB-aligned |
| smp_right | input | 32 | Right sample, LSB-aligned |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Pair taken this cycle (start of left half) |
| fmt_sel | input | 2 | 00/11 standard, 01 left-aligned, 10 right-aligned |
| size_sel | input | 2 | Sample size: 16/20/24/32 bits |
| is_master | input | 1 | 1: block drives the link clocks; 0: follows external clocks |
| half_div | input | DIV_W | Master bit-clock half period, in system clocks minus one |
| bclk_in | input | 1 | External bit clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| wclk_o | output | 1 | Generated word clock (master mode) |
| clk_oe | output | 1 | Clock output enable (high in master mode) |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a frame was sent without a sample pair |

## Verification
The hardest case to reach from the ports is the standard format at the 32-bit size. There the LSB of one word lands in slot 0 of the opposite half. This links the previous frame's right word to the current left half. It is also where a frame that went without data must still pass on a zero carry.

Directed runs select that format and size. One run withholds `smp_valid` exactly at a chosen frame boundary, so the spill-over is checked across a zero-filled frame. Randomly chosen configurations and random sample values cover the remaining placements. The bench drives the slave-mode clocks with a bit clock slow enough to absorb the synchronizer delay.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
package audio_tx_pkg;

  localparam int WORD_W = 32;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef logic [SLOT_W:0] slotx_t;

  localparam logic [1:0] FMT_STD  = 2'b00;
  localparam logic [1:0] FMT_LEFT = 2'b01;
  localparam logic [1:0] FMT_RGT  = 2'b10;
  localparam logic [1:0] FMT_STD2 = 2'b11;

  function automatic slotx_t size_bits(input logic [1:0] sel);
    slotx_t n;
    case (sel)
      2'd0:    n = slotx_t'(16);
      2'd1:    n = slotx_t'(20);
      2'd2:    n = slotx_t'(24);
      default: n = slotx_t'(32);
    endcase
    return n;
  endfunction

  function automatic logic is_std(input logic [1:0] fmt);
    return (fmt == FMT_STD) || (fmt == FMT_STD2);
  endfunction

  // slot that carries the MSB of a word
  function automatic slotx_t first_slot(input logic [1:0] fmt, input logic [1:0] sel);
    slotx_t f;
    if (fmt == FMT_LEFT)     f = '0;
    else if (fmt == FMT_RGT) f = slotx_t'(SLOTS) - size_bits(sel);
    else                     f = slotx_t'(1);
    return f;
  endfunction

  // value of the data line in a given slot of a half
  function automatic logic slot_bit(input logic [WORD_W-1:0] word,
                                    input logic [SLOT_W-1:0] slot,
                                    input logic [1:0]        fmt,
                                    input logic [1:0]        sel,
                                    input logic              carry);
    slotx_t n, f, s, k;
    logic   r;
    n = size_bits(sel);
    f = first_slot(fmt, sel);
    s = {1'b0, slot};
    k = '0;
    r = 1'b0;
    if (is_std(fmt) && (s == '0)) begin
      r = (n == slotx_t'(SLOTS)) ? carry : 1'b0;
    end else if ((s >= f) && ((s - f) < n)) begin
      k = n - (s - f) - slotx_t'(1);
      r = word[k[SLOT_W-1:0]];
    end
    return r;
  endfunction

endpackage

// File: rtl/atx_master_clk.sv
`timescale 1ns/1ps
module atx_master_clk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             fall_evt,
  output logic             wlvl_next,
  output logic             bclk,
  output logic             wclk
);
  import audio_tx_pkg::*;

  logic [DIV_W-1:0]  cnt_q;
  logic              bclk_q;
  logic              wclk_q;
  logic [SLOT_W-1:0] bit_q;
  logic              term;

  assign term      = en && (cnt_q == half_div);
  assign fall_evt  = term && bclk_q;
  assign wlvl_next = (bit_q == SLOT_W'(SLOTS - 1)) ? ~wclk_q : wclk_q;
  assign bclk      = bclk_q;
  assign wclk      = wclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      wclk_q <= 1'b1;
      bit_q  <= SLOT_W'(SLOTS - 1);
    end else if (!en) begin
      cnt_q <= '0;
    end else if (term) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
      if (bclk_q) begin
        bit_q  <= bit_q + SLOT_W'(1);
        wclk_q <= wlvl_next;
      end
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R2
  wclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(wclk_q));

endmodule

// File: rtl/atx_slave_edge.sv
`timescale 1ns/1ps
module atx_slave_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_in,
  input  logic wclk_in,
  output logic fall_evt,
  output logic wlvl
);
  logic [STAGES-1:0] b_sync;
  logic [STAGES-1:0] w_sync;
  logic              b_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sync <= '0;
      w_sync <= {STAGES{1'b1}};
      b_last <= 1'b0;
    end else begin
      b_sync <= {b_sync[STAGES-2:0], bclk_in};
      w_sync <= {w_sync[STAGES-2:0], wclk_in};
      b_last <= b_sync[STAGES-1];
    end
  end

  assign fall_evt = en && b_last && !b_sync[STAGES-1];
  assign wlvl     = w_sync[STAGES-1];

endmodule

// File: rtl/atx_slot_track.sv
`timescale 1ns/1ps
module atx_slot_track (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fall_evt,
  input  logic                            wlvl,
  output logic [audio_tx_pkg::SLOT_W-1:0] slot_nx,
  output logic                            start_left
);
  import audio_tx_pkg::*;

  logic [SLOT_W-1:0] slot_q;
  logic              lvl_q;
  logic              half_edge;

  assign half_edge  = fall_evt && (wlvl != lvl_q);
  assign slot_nx    = half_edge ? '0 : slot_q + SLOT_W'(1);
  assign start_left = half_edge && !wlvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_W'(SLOTS - 1);
      lvl_q  <= 1'b1;
    end else if (fall_evt) begin
      slot_q <= slot_nx;
      lvl_q  <= wlvl;
    end
  end

endmodule

// File: rtl/atx_shifter.sv
`timescale 1ns/1ps
module atx_shifter (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fall_evt,
  input  logic                            start_left,
  input  logic [audio_tx_pkg::SLOT_W-1:0] slot_nx,
  input  logic                            lvl_nx,
  input  logic [1:0]                      fmt_sel,
  input  logic [1:0]                      size_sel,
  input  logic [audio_tx_pkg::WORD_W-1:0] smp_left,
  input  logic [audio_tx_pkg::WORD_W-1:0] smp_right,
  input  logic                            smp_valid,
  output logic                            sdata,
  output logic                            underrun
);
  import audio_tx_pkg::*;

  logic [WORD_W-1:0] left_q, right_q;
  logic [WORD_W-1:0] left_use, right_use, word;
  logic              carry;

  always_comb begin
    left_use  = left_q;
    right_use = right_q;
    if (start_left) begin
      left_use  = smp_valid ? smp_left  : '0;
      right_use = smp_valid ? smp_right : '0;
    end
    word  = lvl_nx ? right_use : left_use;
    // spill-over bit for the standard format at full size
    carry = lvl_nx ? left_use[0] : right_q[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q   <= '0;
      right_q  <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (start_left) begin
        left_q  <= left_use;
        right_q <= right_use;
        if (!smp_valid) underrun <= 1'b1;
      end
      if (fall_evt) sdata <= slot_bit(word, slot_nx, fmt_sel, size_sel, carry);
    end
  end

  // R3
  sdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sdata));

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R9
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_left && !smp_valid) |=> underrun);

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [audio_tx_pkg::WORD_W-1:0] smp_left,
  input  logic [audio_tx_pkg::WORD_W-1:0] smp_right,
  input  logic                            smp_valid,
  output logic                            smp_ready,
  input  logic [1:0]                      fmt_sel,
  input  logic [1:0]                      size_sel,
  input  logic                            is_master,
  input  logic [DIV_W-1:0]                half_div,
  input  logic                            bclk_in,
  input  logic                            wclk_in,
  output logic                            bclk_o,
  output logic                            wclk_o,
  output logic                            clk_oe,
  output logic                            sdata,
  output logic                            underrun
);
  import audio_tx_pkg::*;

  logic              m_fall, m_wlvl, m_bclk, m_wclk;
  logic              s_fall, s_wlvl;
  logic              fall_evt, wlvl;
  logic [SLOT_W-1:0] slot_nx;
  logic              start_left;

  atx_master_clk #(.DIV_W(DIV_W)) u_mclk (
    .clk(clk), .rst_n(rst_n), .en(is_master), .half_div(half_div),
    .fall_evt(m_fall), .wlvl_next(m_wlvl), .bclk(m_bclk), .wclk(m_wclk)
  );

  atx_slave_edge #(.STAGES(SYNC_STAGES)) u_sedge (
    .clk(clk), .rst_n(rst_n), .en(!is_master), .bclk_in(bclk_in),
    .wclk_in(wclk_in), .fall_evt(s_fall), .wlvl(s_wlvl)
  );

  assign fall_evt = is_master ? m_fall : s_fall;
  assign wlvl     = is_master ? m_wlvl : s_wlvl;

  atx_slot_track u_track (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .wlvl(wlvl),
    .slot_nx(slot_nx), .start_left(start_left)
  );

  atx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .start_left(start_left),
    .slot_nx(slot_nx), .lvl_nx(wlvl), .fmt_sel(fmt_sel), .size_sel(size_sel),
    .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
    .sdata(sdata), .underrun(underrun)
  );

  assign smp_ready = start_left;
  assign bclk_o    = is_master & m_bclk;
  assign wclk_o    = is_master & m_wclk;
  assign clk_oe    = is_master;

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !smp_ready);

endmodule

// File: tb/audio_ser_tx_test.sv
`timescale 1ns/1ps
module audio_ser_tx_test;
  localparam int DIV_W = 8;
  localparam int SH    = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [31:0] smp_left = '0, smp_right = '0;
  logic smp_valid = 1'b0, smp_ready;
  logic [1:0] fmt_sel = 2'b01, size_sel = 2'd0;
  logic is_master = 1'b1;
  logic [DIV_W-1:0] half_div = '0;
  logic bclk_in = 1'b0, wclk_in = 1'b1;
  logic bclk_o, wclk_o, clk_oe, sdata, underrun;

  audio_ser_tx #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .fmt_sel(fmt_sel),
    .size_sel(size_sel), .is_master(is_master), .half_div(half_div),
    .bclk_in(bclk_in), .wclk_in(wclk_in), .bclk_o(bclk_o), .wclk_o(wclk_o),
    .clk_oe(clk_oe), .sdata(sdata), .underrun(underrun)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int uf_frame = -1;
  int fcount = 0;
  logic [31:0] ql[$];
  logic [31:0] qr[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bsize(input logic [1:0] sel);
    return 16 + 4 * int'(sel) + ((sel == 2'd3) ? 4 : 0);
  endfunction

  // expected half content; slot s is bit 31-s
  function automatic logic [31:0] half_image(input logic [31:0] w, input logic [31:0] prev,
                                             input logic [1:0] fmt, input logic [1:0] sel);
    int n;
    logic [31:0] v;
    n = bsize(sel);
    v = (n == 32) ? w : (w & ((32'd1 << n) - 32'd1));
    if (fmt == 2'b01) return v << (32 - n);
    if (fmt == 2'b10) return v;
    return ((v << (32 - n)) >> 1) | ((n == 32 && prev[0]) ? 32'h8000_0000 : 32'h0);
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // sample pair source
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && smp_ready) begin
        ql.push_back(smp_valid ? smp_left : 32'h0);
        qr.push_back(smp_valid ? smp_right : 32'h0);
        fcount++;
        @(posedge clk); #1;
        smp_left  = $urandom;
        smp_right = $urandom;
        smp_valid = (fcount != uf_frame);
      end
    end
  end

  // far-end clock source for slave mode
  initial begin
    int ph, sc;
    ph = 0; sc = 31;
    forever begin
      @(posedge clk); #1;
      if (!rst_n || is_master) begin
        ph = 0; sc = 31; bclk_in = 1'b0; wclk_in = 1'b1;
      end else begin
        ph++;
        if (ph == SH) begin
          ph = 0;
          if (bclk_in) begin
            bclk_in = 1'b0;
            sc = (sc + 1) % 32;
            if (sc == 0) wclk_in = ~wclk_in;
          end else bclk_in = 1'b1;
        end
      end
    end
  end

  // serial line monitor
  int hc = 0, nb = 0, last_rise = -1, per_bad = 0;
  logic prevb = 1'b0, curw = 1'b0, started = 1'b0;
  logic [31:0] img = '0;

  task automatic close_half();
    int pair, side;
    logic [31:0] w, pv, ex;
    string tag;
    pair = hc / 2; side = hc % 2;
    check(nb == 32, "R2", "bits per half", nb, 32);
    check(curw == side[0], "R2", "word clock level", {31'b0, curw}, side);
    if (pair < ql.size()) begin
      w  = side ? qr[pair] : ql[pair];
      pv = side ? ql[pair] : ((pair == 0) ? 32'h0 : qr[pair - 1]);
      ex = half_image(w, pv, fmt_sel, size_sel);
      tag = (fmt_sel == 2'b01) ? "R4" : (fmt_sel == 2'b10) ? "R6" : "R5";
      tag = is_master ? {tag, "/R3/R7"} : {"R10/", tag};
      check(img == ex, tag, "half content", img, ex);
    end else check(0, "R8", "missing pair for half", pair, ql.size());
    hc++;
  endtask

  initial begin
    logic bk, wk;
    forever begin
      @(negedge clk);
      bk = is_master ? bclk_o : bclk_in;
      wk = is_master ? wclk_o : wclk_in;
      if (!rst_n) begin
        hc = 0; nb = 0; started = 0; prevb = 0; last_rise = -1; per_bad = 0;
      end else begin
        if (bk && !prevb) begin
          if (is_master) begin
            if (last_rise >= 0 && (cyc - last_rise) != 2 * (int'(half_div) + 1)) per_bad++;
            last_rise = cyc;
          end
          if (!started) begin
            if (!wk) begin started = 1; curw = 1'b0; img = {31'b0, sdata}; nb = 1; end
          end else if (wk != curw) begin
            close_half();
            curw = wk; img = {31'b0, sdata}; nb = 1;
          end else begin
            img = {img[30:0], sdata}; nb++;
          end
        end
        prevb = bk;
      end
    end
  end

  task automatic run_cfg(input bit m, input logic [1:0] f, input logic [1:0] s,
                         input int d, input int frames, input int uf);
    rst_n = 1'b0;
    is_master = m; fmt_sel = f; size_sel = s; half_div = DIV_W'(d);
    uf_frame = uf; fcount = 0; ql.delete(); qr.delete();
    smp_left = $urandom; smp_right = $urandom; smp_valid = (uf != 0);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    while (hc < 2 * frames) @(posedge clk);
    @(negedge clk);
    if (m) begin
      check(per_bad == 0, "R1", "bit clock period errors", per_bad, 0);
      check(clk_oe == 1'b1, "R1", "clock enable in master", clk_oe, 1);
    end else begin
      check({clk_oe, bclk_o, wclk_o} == 3'b000, "R1", "clock outputs in slave",
            {clk_oe, bclk_o, wclk_o}, 0);
    end
    check(ql.size() >= frames, "R8", "ready pulses per frame", ql.size(), frames);
    check(underrun == (uf >= 0 && uf < fcount), "R9", "sticky underrun",
          underrun, (uf >= 0 && uf < fcount));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check({sdata, underrun, smp_ready} == 3'b000, "R11", "reset data/flags",
          {sdata, underrun, smp_ready}, 0);
    check({bclk_o, wclk_o, clk_oe} == 3'b011, "R11", "reset clocks",
          {bclk_o, wclk_o, clk_oe}, 3'b011);

    run_cfg(1, 2'b01, 2'd2, 1, 3, -1);
    run_cfg(1, 2'b01, 2'd0, 0, 3, -1);
    run_cfg(1, 2'b00, 2'd3, 1, 3, -1);
    run_cfg(1, 2'b00, 2'd1, 2, 3, -1);
    run_cfg(1, 2'b10, 2'd0, 1, 3, -1);
    run_cfg(1, 2'b10, 2'd3, 1, 3, -1);
    run_cfg(1, 2'b11, 2'd2, 1, 3, -1);
    run_cfg(1, 2'b01, 2'd1, 1, 3, 1);   // R9 mid-stream underrun
    run_cfg(1, 2'b00, 2'd3, 0, 3, 1);   // R5 carry across zero frame
    for (int i = 0; i < 3; i++)
      run_cfg(1, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              $urandom_range(0, 3), 3, -1);
    run_cfg(0, 2'b00, 2'd1, 0, 3, -1);  // R10
    run_cfg(0, 2'b10, 2'd2, 0, 3, -1);
    run_cfg(0, 2'b01, 2'd3, 0, 3, 0);
    run_cfg(0, 2'b00, 2'd3, 0, 3, -1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule